// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a bank of general-purpose input pins and raises a single interrupt request when any enabled pin meets its trigger condition. Software chooses, per pin, among four triggers: active-high level, active-low level, one edge (rising or falling), or both edges. The pins are asynchronous to the block clock, so each one is first passed through a two-flop synchroniser. Edges are found by comparing the synchronised value with its value one clock earlier.

Each pin owns one pending flag. In an edge mode the flag is sticky: an edge sets it, and only a write-one-to-clear removes it. In level mode the flag simply tracks whether the level is active, so a clear issued while the level is still present has no lasting effect. A mask register gates the flags, and the OR of the masked flags drives the interrupt output through a register.

Configuration uses a plain 32-bit read/write strobe bus. Read data is registered and appears one cycle after the read strobe. A read-only version word reports a value of at least 3, which tells software that the both-edges register is present. Offsets: 0x0C pending (read-only), 0x10 enable mask, 0x14 clear (write-only, reads 0), 0x18 mode select (1 = edge, 0 = level), 0x1C polarity, 0x20 version, 0x24 both-edges.

Top module: `gpio_irq_unit`

## Requirements
- R1: After a synchronous reset, the enable, mode, polarity, both-edges and pending bits are all 0, and `irq` is 0.
- R2: A read of offset 0x20 returns the parameter `VERSION` (default 3, always at least 3). Reads of unmapped offsets and of the clear offset 0x14 return 0. Read data is presented on the cycle after `rd_en`.
- R3: A pin whose mode bit (0x18) is 0 is level triggered. Its pending bit equals (synchronised pin == polarity bit), so polarity 1 means active-high and 0 means active-low.
- R4: A pin whose mode bit is 1 and whose both-edges bit is 0 sets its pending bit on a rising edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0. An edge in the other direction leaves the bit unchanged. The bit stays set after the pin returns.
- R5: A pin whose mode bit and both-edges bit (0x24) are both 1 sets its pending bit on every transition, whatever its polarity bit holds.
- R6: Writing a word to 0x14 clears the pending bit of each pin whose bit in the word is 1. Bits that are 0 leave their pins untouched. For a level-mode pin whose level is still active, the bit is set again on the next cycle.
- R7: If an edge event for a pin falls in the same cycle as a clear write for that pin, the pending bit stays set.
- R8: `irq` is a register equal to the OR over all pins of (pending AND enable), delayed by one cycle.
- R9: The enable, mode, polarity and both-edges registers read back what was written. Bits at or above `NPINS` read as 0 in every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPINS | Asynchronous input pins |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid one cycle after rd_en |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The hazard is a clear write and a new edge on the same pin landing in one cycle, because the clear then competes with the flag update. The bench first clears an edge-mode pin, then toggles the pin. It places the clear write exactly in the cycle where the edge leaves the synchroniser, counting the two synchroniser stages and the history stage. The result is judged by reading the pending word afterwards: it must still hold that pin's bit. A later clear must remove the bit, which shows that the first clear was overruled by the edge and did not simply miss.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int DATA_W = 32;

  // register byte offsets
  localparam int OFS_PEND  = 'h0C;
  localparam int OFS_EN    = 'h10;
  localparam int OFS_CLR   = 'h14;
  localparam int OFS_MODE  = 'h18;
  localparam int OFS_POL   = 'h1C;
  localparam int OFS_VER   = 'h20;
  localparam int OFS_BOTH  = 'h24;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_RISE  = 2'd1,
    TRIG_FALL  = 2'd2,
    TRIG_BOTH  = 2'd3
  } trig_e;

  // both-edges overrides the polarity-chosen single edge
  function automatic trig_e classify(input logic edge_mode, input logic both,
                                     input logic pol);
    if (!edge_mode)  return TRIG_LEVEL;
    else if (both)   return TRIG_BOTH;
    else if (pol)    return TRIG_RISE;
    else             return TRIG_FALL;
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] sync_q,
  output logic [N-1:0] prev_q
);

  logic [N-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= pin_in;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= chain[STAGES-1];
  end

  assign sync_q = chain[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sync_q,
  input  logic [N-1:0] prev_q,
  input  logic [N-1:0] mode,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] both,
  input  logic [N-1:0] clr,
  output logic [N-1:0] evt,
  output logic [N-1:0] pend_q
);

  logic [N-1:0] pend_d;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pin
      trig_e kind;
      always_comb begin
        kind = classify(mode[i], both[i], pol[i]);
        unique case (kind)
          TRIG_LEVEL: evt[i] = (sync_q[i] == pol[i]);
          TRIG_RISE:  evt[i] = sync_q[i] & ~prev_q[i];
          TRIG_FALL:  evt[i] = ~sync_q[i] & prev_q[i];
          default:    evt[i] = sync_q[i] ^ prev_q[i];
        endcase
        // level: follow qualified level; edge: sticky, event beats clear
        if (kind == TRIG_LEVEL) pend_d[i] = evt[i];
        else                    pend_d[i] = (pend_q[i] & ~clr[i]) | evt[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int N       = 32,
  parameter int AW      = 8,
  parameter int VERSION = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N-1:0]      pend,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      mode_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      both_q,
  output logic [N-1:0]      clr_mask,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [AW-1:0] A_PEND = AW'(OFS_PEND);
  localparam logic [AW-1:0] A_EN   = AW'(OFS_EN);
  localparam logic [AW-1:0] A_CLR  = AW'(OFS_CLR);
  localparam logic [AW-1:0] A_MODE = AW'(OFS_MODE);
  localparam logic [AW-1:0] A_POL  = AW'(OFS_POL);
  localparam logic [AW-1:0] A_VER  = AW'(OFS_VER);
  localparam logic [AW-1:0] A_BOTH = AW'(OFS_BOTH);

  logic [N-1:0]      wbits;
  logic [DATA_W-1:0] rd_word;

  assign wbits    = wdata[N-1:0];
  assign clr_mask = (wr_en && addr == A_CLR) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      both_q <= '0;
    end else if (wr_en) begin
      unique case (addr)
        A_EN:    en_q   <= wbits;
        A_MODE:  mode_q <= wbits;
        A_POL:   pol_q  <= wbits;
        A_BOTH:  both_q <= wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      A_PEND:  rd_word = DATA_W'(pend);
      A_EN:    rd_word = DATA_W'(en_q);
      A_MODE:  rd_word = DATA_W'(mode_q);
      A_POL:   rd_word = DATA_W'(pol_q);
      A_BOTH:  rd_word = DATA_W'(both_q);
      A_VER:   rd_word = DATA_W'(VERSION);
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int AW      = 8,
  parameter int VERSION = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  logic [NPINS-1:0] sync_q, prev_q, evt, pend_q;
  logic [NPINS-1:0] en_q, mode_q, pol_q, both_q, clr_mask;

  gpio_irq_sync #(.N(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .sync_q(sync_q), .prev_q(prev_q)
  );

  gpio_irq_detect #(.N(NPINS)) u_detect (
    .clk(clk), .rst(rst), .sync_q(sync_q), .prev_q(prev_q),
    .mode(mode_q), .pol(pol_q), .both(both_q), .clr(clr_mask),
    .evt(evt), .pend_q(pend_q)
  );

  gpio_irq_regs #(.N(NPINS), .AW(AW), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .pend(pend_q), .en_q(en_q), .mode_q(mode_q),
    .pol_q(pol_q), .both_q(both_q), .clr_mask(clr_mask), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(pend_q & en_q);
  end

endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
  import gpio_irq_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic [N-1:0]      pend,
  input logic [N-1:0]      en,
  input logic [N-1:0]      mode,
  input logic [N-1:0]      pol,
  input logic [N-1:0]      sync,
  input logic [N-1:0]      evt,
  input logic [N-1:0]      clr,
  input logic              rd_en,
  input logic [AW-1:0]     addr,
  input logic [DATA_W-1:0] rdata
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!irq && pend == '0)); // R1

  AST_VERSION_MIN: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(OFS_VER)) |=> (rdata >= 32'd3)); // R2

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((~$past(mode) & (pend ^ ~($past(sync) ^ $past(pol)))) == '0)); // R3

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(pend) & $past(mode) & ~$past(clr) & ~pend) == '0)); // R4

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(clr) & $past(evt) & ~pend) == '0)); // R7

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past(|(pend & en)))); // R8

endmodule

bind gpio_irq_unit gpio_irq_checker #(.N(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .pend(pend_q), .en(en_q), .mode(mode_q),
  .pol(pol_q), .sync(sync_q), .evt(evt), .clr(clr_mask), .rd_en(rd_en),
  .addr(addr), .rdata(rdata)
);

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;
  localparam int N  = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pins;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  always #5 clk = ~clk;

  gpio_irq_unit #(.NPINS(N), .AW(AW), .VERSION(3)) u_gpio_irq_unit (
    .clk(clk), .rst(rst), .pin_in(pins), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  int checks = 0, errors = 0;
  logic rd_q = 1'b0;

  always @(posedge clk) rd_q <= rd_en;

  // monitor: compares registered read data with the scoreboard head
  always @(negedge clk) begin
    item_t it;
    if (rd_q) begin
      checks++;
      if (sbq.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: rdata=%h expected=<none>", rdata);
      end else begin
        it = sbq.pop_front();
        if (rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    addr = AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq=%b expected=%b", tag, irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pins = 8'hEA;
    idle(4);
    rst = 1'b0;
    idle(5);

    // R1 reset state (pins high enough that level-low defaults are idle on 7:5)
    rd('h10, 32'h0, "R1 enable");
    rd('h18, 32'h0, "R1 mode");
    rd('h1C, 32'h0, "R1 polarity");
    rd('h24, 32'h0, "R1 both");
    chk_irq(1'b0, "R1 irq");

    // R2 version and unmapped
    rd('h20, 32'd3, "R2 version");
    rd('h00, 32'h0, "R2 unmapped");
    rd('h14, 32'h0, "R2 clear reads zero");

    // R9 upper bits read zero
    wr('h10, 32'hFFFF_FFFF);
    rd('h10, 32'h0000_00FF, "R9 enable width");
    wr('h10, 32'h0);

    // pin0 lvl-high, pin1 lvl-low, pin2 rise, pin3 fall, pin4 both
    wr('h18, 32'h1C);
    wr('h1C, 32'h05);
    wr('h24, 32'h10);
    wr('h14, 32'hFF);
    idle(1);
    rd('h18, 32'h1C, "R9 mode readback");
    rd('h1C, 32'h05, "R9 polarity readback");
    rd('h24, 32'h10, "R9 both readback");
    rd('h0C, 32'h0, "R6 all cleared");

    // R3 level modes
    pins[0] = 1'b1; idle(4);
    rd('h0C, 32'h01, "R3 active-high set");
    wr('h14, 32'h01); idle(1);
    rd('h0C, 32'h01, "R6 level clear no lasting effect");
    pins[0] = 1'b0; idle(4);
    rd('h0C, 32'h00, "R3 active-high released");
    pins[1] = 1'b0; idle(4);
    rd('h0C, 32'h02, "R3 active-low set");
    pins[1] = 1'b1; idle(4);
    rd('h0C, 32'h00, "R3 active-low released");

    // R4 rising edge, sticky
    pins[2] = 1'b1; idle(4);
    rd('h0C, 32'h04, "R4 rising sets");
    pins[2] = 1'b0; idle(4);
    rd('h0C, 32'h04, "R4 sticky after return");
    wr('h14, 32'h01); idle(1);
    rd('h0C, 32'h04, "R6 zero bit no effect");
    wr('h14, 32'h04); idle(1);
    rd('h0C, 32'h00, "R6 one bit clears");
    // R4 falling edge
    pins[3] = 1'b0; idle(4);
    rd('h0C, 32'h08, "R4 falling sets");
    wr('h14, 32'h08);
    pins[3] = 1'b1; idle(4);
    rd('h0C, 32'h00, "R4 rise ignored on falling pin");
    pins[2] = 1'b1; idle(4);
    wr('h14, 32'h04);
    pins[2] = 1'b0; idle(4);
    rd('h0C, 32'h00, "R4 fall ignored on rising pin");

    // R5 both edges, polarity irrelevant
    pins[4] = 1'b1; idle(4);
    rd('h0C, 32'h10, "R5 rise with pol0");
    wr('h14, 32'h10);
    pins[4] = 1'b0; idle(4);
    rd('h0C, 32'h10, "R5 fall with pol0");
    wr('h14, 32'h10);
    wr('h1C, 32'h15);
    pins[4] = 1'b1; idle(4);
    rd('h0C, 32'h10, "R5 rise with pol1");
    wr('h14, 32'h10);
    pins[4] = 1'b0; idle(4);
    rd('h0C, 32'h10, "R5 fall with pol1");
    wr('h14, 32'h10); idle(1);

    // R8 masking and irq latency
    pins[2] = 1'b1; idle(4);
    chk_irq(1'b0, "R8 masked");
    wr('h10, 32'h04); idle(1);
    chk_irq(1'b1, "R8 enabled");
    wr('h10, 32'h00); idle(1);
    chk_irq(1'b0, "R8 re-masked");
    wr('h10, 32'h04);
    wr('h14, 32'h04); idle(1);
    chk_irq(1'b0, "R8 cleared");

    // R7 edge and clear in the same cycle (pin3 falling)
    pins[3] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr('h14, 32'h08);
    idle(2);
    rd('h0C, 32'h08, "R7 edge beats clear");
    wr('h14, 32'h08); idle(1);
    rd('h0C, 32'h00, "R7 later clear works");

    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule